// File: doc/BRIEF.md
# Noise-Shaped Digital Phase Quantizer

This block turns a stream of fine-resolution phase samples into a coarse select code for a bank of equally spaced carrier phases. Each accepted sample is reduced to one of M = 2^IDX_W positions around the circle. The select code can drive the select bus of a phase multiplexer or of a digital phase interpolator. A second-order error-feedback loop shapes the quantization noise with (1 - z^-1)^2. The noise is therefore small close to the carrier and is pushed out to large frequency offsets.

Alongside the index, the block reports the exact signed difference between the phase it selected and the phase it was asked for. A separate cancellation path can use this difference to remove the residual noise. An optional accumulator adds a programmable increment to the requested phase on every accepted sample. A constant increment gives a phase ramp, which places the output at a fixed frequency offset from the carrier. All phase arithmetic is circular: a full-scale input word is one full turn, and both the index and the error wrap accordingly.

Top module: `phase_nsq`

## Requirements
- R1: A synchronous active-high `rst` clears the feedback state and the ramp accumulator. While `rst` is high and in the first cycle after it, `out_valid`, `out_index` and `out_err` are 0.
- R2: `out_valid` is high in exactly the cycle after an edge at which `in_valid` was high, and low otherwise.
- R3: For an accepted sample with effective phase x, the loop word is u = (x - 2*e[n-1] + e[n-2]) mod 2^IN_W. The index is floor((u + STEP/2) / STEP) mod M, with STEP = 2^(IN_W-IDX_W) (2048 by default). The stored residue is e[n] = index*STEP - u, wrapped to the signed range, and lies in [-STEP/2+1, STEP/2].
- R4: `out_err` is the shortest signed circular difference index*STEP - x, in two's complement, ERR_W = IN_W-IDX_W+2 bits wide (13 by default). It belongs to the same sample as `out_index`.
- R5: The index wraps modulo M. From cleared state, x = 0xF800 gives index 31 and error 0; x = 0xFC00 gives index 0 and error +1024; x = 0x7FFF gives index 16 and error +1.
- R6: When `ramp_en` is high on an accepted sample, x = `in_phase` + acc (mod 2^IN_W) and acc then advances by `ramp_step`. When `ramp_en` is low on an accepted sample, x = `in_phase` and acc returns to 0. acc starts at 0 after reset.
- R7: A cycle with `in_valid` low changes no loop state or accumulator, and `out_index`/`out_err` keep their last values.
- R8: Every valid `out_err` lies within ±(2*STEP - 2), which is ±4094 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the phase switching rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_phase` in this cycle |
| in_phase | input | IN_W | Requested phase, two's complement, full scale is one turn |
| ramp_en | input | 1 | Adds the ramp accumulator to the requested phase |
| ramp_step | input | IN_W | Increment added to the accumulator per accepted sample |
| out_valid | output | 1 | Marks a fresh index/error pair |
| out_index | output | IDX_W | Selected phase position, 0 to M-1 |
| out_err | output | ERR_W | Selected phase minus requested phase, signed |

## Verification
Every result of an accepted sample is registered once, so the index, the error and `out_valid` are all due on the first rising edge after the sample is driven. The bench drives on the falling edge and compares on the next falling edge, against a reference that advances its loop state and accumulator only for accepted samples. Idle cycles are checked in that same slot: the outputs must still hold the previous values. The residue, wrap and accumulator effects of an accepted sample then show up in the index and error of the next accepted sample, however many idle cycles lie between the two.

// File: rtl/pq_pkg.sv
package pq_pkg;
   localparam int PQ_IN_W_DEF  = 16;
   localparam int PQ_IDX_W_DEF = 5;

   typedef enum logic {
      PQ_SRC_DIRECT = 1'b0,
      PQ_SRC_RAMP   = 1'b1
   } pq_src_e;
endpackage

// File: rtl/pq_ramp_acc.sv
module pq_ramp_acc #(
   parameter int IN_W     = 16,
   parameter bit HAS_RAMP = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   input  logic            ramp_en,
   input  logic [IN_W-1:0] ramp_step,
   input  logic [IN_W-1:0] in_phase,
   output logic [IN_W-1:0] eff_phase
);
   import pq_pkg::*;

   generate
      if (HAS_RAMP) begin : g_ramp
         logic [IN_W-1:0] acc;
         pq_src_e         src;

         assign src       = ramp_en ? PQ_SRC_RAMP : PQ_SRC_DIRECT;
         assign eff_phase = (src == PQ_SRC_RAMP) ? in_phase + acc : in_phase;

         always_ff @(posedge clk) begin
            if (rst) begin
               acc <= '0;
            end else if (adv) begin
               if (src == PQ_SRC_RAMP) acc <= acc + ramp_step;
               else                    acc <= '0;
            end
         end

         // R6: a direct-mode sample returns the accumulator to zero
         assert_acc_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (adv && !ramp_en) |=> (acc == '0));
         // R7: idle cycles leave the accumulator untouched
         assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !adv |=> $stable(acc));
      end else begin : g_direct
         assign eff_phase = in_phase;
      end
   endgenerate
endmodule

// File: rtl/pq_rounder.sv
module pq_rounder #(
   parameter int IN_W  = 16,
   parameter int IDX_W = 5,
   localparam int FRAC_W = IN_W - IDX_W,
   localparam int RES_W  = FRAC_W + 1
) (
   input  logic [IN_W-1:0]         loop_word,
   output logic [IDX_W-1:0]        sel_idx,
   output logic signed [RES_W-1:0] residue
);
   localparam logic [IN_W-1:0]  HALF_W = IN_W'(1) << (FRAC_W - 1);
   localparam logic [RES_W-1:0] HALF_R = RES_W'(1) << (FRAC_W - 1);

   logic [IN_W-1:0] biased;

   always_comb begin
      biased  = loop_word + HALF_W;
      sel_idx = biased[IN_W-1:FRAC_W];
      residue = $signed(HALF_R - {1'b0, biased[FRAC_W-1:0]});
   end
endmodule

// File: rtl/pq_err_fb.sv
module pq_err_fb #(
   parameter int IN_W  = 16,
   parameter int RES_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    adv,
   input  logic signed [RES_W-1:0] res_now,
   output logic [IN_W-1:0]         fb_word
);
   localparam int FB_W = RES_W + 2;
   localparam logic signed [RES_W-1:0] RES_HI = RES_W'(1) << (RES_W - 2);

   logic signed [RES_W-1:0] res_d1, res_d2;
   logic signed [FB_W-1:0]  fb_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         res_d1 <= '0;
         res_d2 <= '0;
      end else if (adv) begin
         res_d1 <= res_now;
         res_d2 <= res_d1;
      end
   end

   always_comb begin
      fb_n    = {res_d1[RES_W-1], res_d1, 1'b0} - {{2{res_d2[RES_W-1]}}, res_d2};
      fb_word = {{(IN_W-FB_W){fb_n[FB_W-1]}}, fb_n};
   end

   // R3: the stored residue stays within half a step of the chosen phase
   assert_residue_range_R3: assert property (@(posedge clk) disable iff (rst)
      (res_d1 <= RES_HI) && (res_d1 > -RES_HI));
   // R7: idle cycles leave the feedback delay line untouched
   assert_fb_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(res_d1) && $stable(res_d2)));
endmodule

// File: rtl/phase_nsq.sv
module phase_nsq #(
   parameter int IN_W     = pq_pkg::PQ_IN_W_DEF,
   parameter int IDX_W    = pq_pkg::PQ_IDX_W_DEF,
   parameter bit HAS_RAMP = 1'b1,
   localparam int ERR_W   = IN_W - IDX_W + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_phase,
   input  logic             ramp_en,
   input  logic [IN_W-1:0]  ramp_step,
   output logic             out_valid,
   output logic [IDX_W-1:0] out_index,
   output logic [ERR_W-1:0] out_err
);
   localparam int FRAC_W = IN_W - IDX_W;
   localparam int RES_W  = FRAC_W + 1;
   localparam int ERR_LIM = (2 << FRAC_W) - 2;

   generate
      if (IDX_W < 3 || IDX_W > IN_W - 4) begin : g_bad_idx
         $error("phase_nsq: IDX_W must lie in 3..IN_W-4");
      end
   endgenerate

   logic [IN_W-1:0]         eff_phase;
   logic [IN_W-1:0]         fb_word;
   logic [IN_W-1:0]         loop_word;
   logic [IDX_W-1:0]        q_idx;
   logic signed [RES_W-1:0] q_res;
   logic [IN_W-1:0]         diff;

   pq_ramp_acc #(.IN_W(IN_W), .HAS_RAMP(HAS_RAMP)) u_ramp (
      .clk(clk), .rst(rst), .adv(in_valid), .ramp_en(ramp_en),
      .ramp_step(ramp_step), .in_phase(in_phase), .eff_phase(eff_phase)
   );

   pq_rounder #(.IN_W(IN_W), .IDX_W(IDX_W)) u_round (
      .loop_word(loop_word), .sel_idx(q_idx), .residue(q_res)
   );

   pq_err_fb #(.IN_W(IN_W), .RES_W(RES_W)) u_fb (
      .clk(clk), .rst(rst), .adv(in_valid), .res_now(q_res), .fb_word(fb_word)
   );

   always_comb begin
      loop_word = eff_phase - fb_word;
      diff      = {q_idx, {FRAC_W{1'b0}}} - eff_phase;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_index <= '0;
         out_err   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_index <= q_idx;
            out_err   <= diff[ERR_W-1:0];
         end
      end
   end

   // R4: the circular difference always fits the narrowed error port
   assert_err_fits_R4: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ((diff[IN_W-1:ERR_W-1] == '0) || (diff[IN_W-1:ERR_W-1] == '1)));
   // R2: one-cycle latency from accepted sample to output strobe
   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R7: outputs hold across idle cycles
   assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_index) && $stable(out_err)));
   // R8: reported error bounded by the second-order shaping limit
   assert_err_bound_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (($signed(out_err) <= ERR_LIM) && ($signed(out_err) >= -ERR_LIM)));
endmodule

// File: tb/tb_phase_nsq.sv
module tb_phase_nsq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_phase = '0;
   logic        ramp_en = 1'b0;
   logic [15:0] ramp_step = '0;
   logic        out_valid;
   logic [4:0]  out_index;
   logic [12:0] out_err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int m_e1, m_e2, m_acc;
   int x_idx, x_err;
   bit x_valid;

   always #10 clk = ~clk;

   phase_nsq dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
      .ramp_en(ramp_en), .ramp_step(ramp_step), .out_valid(out_valid),
      .out_index(out_index), .out_err(out_err)
   );

   function automatic int wrap16(int v);
      int w;
      w = v & 32'hFFFF;
      if (w >= 32768) w = w - 65536;
      return w;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare(string req);
      check(out_valid == x_valid, "R2", "out_valid", int'(out_valid), int'(x_valid));
      check(int'(out_index) == x_idx, req, "index", int'(out_index), x_idx);
      check(int'($signed(out_err)) == x_err, req, "error", int'($signed(out_err)), x_err);
      if (x_valid)
         check((x_err <= 4094) && (x_err >= -4094), "R8", "error bound",
               int'($signed(out_err)), 4094);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      repeat (2) @(posedge clk);
      m_e1 = 0; m_e2 = 0; m_acc = 0;
      x_idx = 0; x_err = 0; x_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0 && out_index == '0 && out_err == '0, "R1",
            "reset outputs", int'(out_index) + int'(out_err) + int'(out_valid), 0);
      rst = 1'b0;
   endtask

   task automatic step(bit v, int ph, bit ren, int st, string req);
      int x, u, e;
      in_valid = v; in_phase = 16'(ph); ramp_en = ren; ramp_step = 16'(st);
      @(posedge clk);
      x_valid = v;
      if (v) begin
         x = (ph + (ren ? m_acc : 0)) & 32'hFFFF;
         u = (x - 2 * m_e1 + m_e2) & 32'hFFFF;
         x_idx = ((u + 1024) >> 11) & 31;
         e = wrap16(x_idx * 2048 - u);
         x_err = wrap16(x_idx * 2048 - x);
         m_e2 = m_e1; m_e1 = e;
         m_acc = ren ? ((m_acc + st) & 32'hFFFF) : 0;
      end
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      do_reset();
      // R1: a zero sample straight after reset sees cleared feedback
      step(1, 0, 0, 0, "R1");
      step(0, 0, 0, 0, "R7");
      // R5: wrap corners from cleared state
      do_reset(); step(1, 16'hF800, 0, 0, "R5");
      check(x_idx == 31 && x_err == 0, "R5", "idx 0xF800", x_idx, 31);
      do_reset(); step(1, 16'hFC00, 0, 0, "R5");
      check(x_idx == 0 && x_err == 1024, "R5", "idx 0xFC00", x_idx, 0);
      do_reset(); step(1, 16'h7FFF, 0, 0, "R5");
      check(x_idx == 16 && x_err == 1, "R5", "idx 0x7FFF", x_idx, 16);
      // R3 and R4: constant input exercises the second-order feedback
      do_reset();
      for (int i = 0; i < 8; i++) step(1, 1024, 0, 0, "R3");
      for (int i = 0; i < 8; i++) step(1, 16'h2345, 0, 0, "R4");
      // R7: idle gaps between samples must not advance state
      for (int i = 0; i < 6; i++) begin
         step(0, 16'h5555, 1, 999, "R7");
         step(1, 16'h1111 * i, 0, 0, "R7");
      end
      // R6: ramp from cleared accumulator, then back to direct mode
      do_reset();
      for (int i = 0; i < 10; i++) step(1, 0, 1, 300, "R6");
      step(1, 16'h0400, 0, 0, "R6");
      for (int i = 0; i < 5; i++) step(1, 100, 1, 16'hFF00, "R6");
      // R3 R6 R8: constrained random mix
      for (int i = 0; i < 3000; i++) begin
         bit v, ren;
         int ph, st;
         v = ($urandom % 4) != 0;
         ren = ((i / 200) % 2) == 1;
         st = ($urandom % 2) ? int'($urandom % 512) : int'($urandom & 32'hFFFF);
         ph = ((i / 100) % 3 == 0) ? int'($urandom & 32'hFFFF)
                                   : int'((i * 37 + ($urandom % 64)) & 32'hFFFF);
         step(v, ph, ren, st, ren ? "R6" : "R3");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule